// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable, register-array model of a pipelined synchronous SRAM that needs no idle cycles when the bus switches between reads and writes. All command inputs are captured on the rising clock edge. An access is started by a load cycle (`adv_ld` = 0). A follow-on access is started by an advance cycle (`adv_ld` = 1). An advance cycle steps a two-bit burst counter that was seeded from the two lowest address bits.

Reads and writes share one latency. For a write, the data and the byte-masked store come two enabled edges after the address. For a read, the word appears on `rdata` two enabled edges after the address, with `rvalid` raised. Because of this, a read may directly follow a write, or a write a read, with no gap between them. A high `cen_n` freezes the whole pipeline, the storage and the outputs, as if the edge had not happened.

The burst controller is a three-state machine: `ST_IDLE`, `ST_RBURST` and `ST_WBURST`. Every transition between its states happens on an enabled edge:
- a load with `chip_sel` = 1 and `we_n` = 1 enters `ST_RBURST`;
- a load with `chip_sel` = 1 and `we_n` = 0 enters `ST_WBURST`;
- a load with `chip_sel` = 0 (a deselect) enters `ST_IDLE`;
- an advance cycle keeps the current state and issues that state's operation again: read, write or none.

Top module: `lw_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rvalid` is 0 and `rdata` is all zeros until the first read reaches the output.
- R2: A load read is `adv_ld`=0, `chip_sel`=1 and `we_n`=1 on an edge with `cen_n`=0. After two more enabled edges, `rdata` holds the stored word at that address and `rvalid`=1.
- R3: A load write is `adv_ld`=0, `chip_sel`=1 and `we_n`=0. The write data are sampled from `wdata` on the second enabled edge after the address edge. Only the lanes whose `bw_n` bit was low on the address edge are stored. Bit i of `bw_n` controls data bits [9i+8:9i].
- R4: Reads and writes may be issued on consecutive edges with no idle cycle. Every read returns the newest value, including the value of a write issued one edge before it.
- R5: An advance cycle (`adv_ld`=1) increments the low two address bits modulo 4 and keeps the upper bits. It repeats the operation type of the last load and ignores `chip_sel` and `we_n`. On a write burst, `bw_n` is sampled on each advance edge.
- R6: Advance cycles that follow a deselect perform no access: nothing is stored and `rvalid` stays 0.
- R7: When a deselect or a write reaches the output stage, `rvalid` falls to 0 and `rdata` keeps its last value.
- R8: On read cycles (`we_n`=1), `bw_n` and `wdata` have no effect on the stored contents.
- R9: An edge with `cen_n`=1 changes nothing. `rdata`, `rvalid`, the pipeline and the storage all hold. The other inputs are ignored on that edge, and the pending accesses complete on later enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline and outputs |
| cen_n | input | 1 | Active-low clock enable; high freezes everything |
| chip_sel | input | 1 | Device select, sampled on load cycles |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| we_n | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| bw_n | input | LANES | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address, low two bits seed the burst |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the address |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High when `rdata` carries a completed read |

## Verification
The bench issues a write, then a read of the same address on the very next edge, then more reads and writes interleaved. A design that stored one edge too late, or read the array one stage too early, would return stale data. It runs a four-beat burst that starts at low bits 2, so it wraps from 3 to 0. A carry into the upper address bits, or a failure to wrap, would read or write the wrong words. It inserts stalls between the address and the data of a write, with garbage on `wdata` during the stalled cycles. A design that still advanced on a stalled edge would store the garbage, or drop `rvalid` early. It also sends advance cycles after a deselect, and reads with every `bw_n` bit low. A design that fell back to a default operation would raise `rvalid` or corrupt the stored words.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Width of the burst counter held in the low address bits
    localparam int CNT_W = 2;

    // Operation carried down the pipeline
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Burst controller state
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RBURST = 2'd1,
        ST_WBURST = 2'd2
    } burst_st_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
// Burst controller and first pipeline stage: decodes load/advance cycles
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              chip_sel,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op1,
    output logic [ADDR_W-1:0] addr1,
    output logic [LANES-1:0]  bw1
);

    burst_st_e         st_q, st_nxt;
    op_e               op_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic [LANES-1:0]  bw_nxt;
    logic [CNT_W-1:0]  cnt_inc;

    // Linear wrap inside a group of four words
    assign cnt_inc = addr1[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (en) begin
            st_q <= st_nxt;
        end
    end

    // Next state and stage-one values
    always_comb begin
        st_nxt   = st_q;
        op_nxt   = OP_IDLE;
        addr_nxt = addr1;
        bw_nxt   = '0;
        if (!adv_ld) begin
            if (chip_sel) begin
                addr_nxt = addr;
                if (we_n) begin
                    st_nxt = ST_RBURST;
                    op_nxt = OP_READ;
                end else begin
                    st_nxt = ST_WBURST;
                    op_nxt = OP_WRITE;
                    bw_nxt = ~bw_n;
                end
            end else begin
                st_nxt = ST_IDLE;
            end
        end else begin
            addr_nxt = {addr1[ADDR_W-1:CNT_W], cnt_inc};
            unique case (st_q)
                ST_RBURST: op_nxt = OP_READ;
                ST_WBURST: begin
                    op_nxt = OP_WRITE;
                    bw_nxt = ~bw_n;
                end
                default:   op_nxt = OP_IDLE;
            endcase
        end
    end

    // Stage-one output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op1   <= OP_IDLE;
            addr1 <= '0;
            bw1   <= '0;
        end else if (en) begin
            op1   <= op_nxt;
            addr1 <= addr_nxt;
            bw1   <= bw_nxt;
        end
    end

endmodule

// File: rtl/lw_sram_stage.sv
// Second pipeline stage: holds the access while its data arrive
module lw_sram_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_e               op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LANES-1:0]  bw_in,
    output op_e               op_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LANES-1:0]  bw_out
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_out   <= OP_IDLE;
            addr_out <= '0;
            bw_out   <= '0;
        end else if (en) begin
            op_out   <= op_in;
            addr_out <= addr_in;
            bw_out   <= bw_in;
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
// Storage with per-lane write and registered read output
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  op_e                     op2,
    input  logic [ADDR_W-1:0]       addr2,
    input  logic [LANES-1:0]        bw2,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] rd_word;

    // One storage column per byte lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (en && (op2 == OP_WRITE) && bw2[l]) begin
                cells[addr2] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rd_word[l*LANE_W +: LANE_W] = cells[addr2];
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (en) begin
            unique case (op2)
                OP_READ: begin
                    rdata  <= rd_word;
                    rvalid <= 1'b1;
                end
                default: rvalid <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lw_sram.sv
// Late-write pipelined SRAM top
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    chip_sel,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    op_e               op1, op2;
    logic [ADDR_W-1:0] burst_addr, addr2;
    logic [LANES-1:0]  bw1, bw2;

    assign en = ~cen_n;

    lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .chip_sel (chip_sel),
        .adv_ld   (adv_ld),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .addr     (addr),
        .op1      (op1),
        .addr1    (burst_addr),
        .bw1      (bw1)
    );

    lw_sram_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .op_in    (op1),
        .addr_in  (burst_addr),
        .bw_in    (bw1),
        .op_out   (op2),
        .addr_out (addr2),
        .bw_out   (bw2)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .op2    (op2),
        .addr2  (addr2),
        .bw2    (bw2),
        .wdata  (wdata[DATA_W-1:0]),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

endmodule

// File: rtl/lw_sram_chk.sv
// Property checker, bound to the top module
module lw_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              chip_sel,
    input logic              adv_ld,
    input logic              we_n,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic [ADDR_W-1:0] addr1
);

    AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(rvalid)); // R9

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(rdata)); // R9

    AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(addr1)); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_sel && we_n) ##1 !cen_n ##1 !cen_n |=> rvalid); // R2

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_sel && !we_n) ##1 !cen_n ##1 !cen_n |=> !rvalid); // R7

    AST_DESELECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chip_sel) ##1 !cen_n ##1 !cen_n |=> !rvalid); // R7

    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chip_sel) ##1 (!cen_n && adv_ld) ##1 !cen_n ##1 !cen_n
        |=> !rvalid); // R6

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld) |=> addr1[1:0] == 2'($past(addr1[1:0]) + 2'd1)); // R5

    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld) |=> addr1[ADDR_W-1:2] == $past(addr1[ADDR_W-1:2])); // R5

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .chip_sel (chip_sel),
    .adv_ld   (adv_ld),
    .we_n     (we_n),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .addr1    (burst_addr)
);

// File: tb/lw_sram_bench.sv
module lw_sram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int LANES      = 4;
    localparam int LANE_W     = 9;
    localparam int DATA_W     = LANES * LANE_W;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cen_n;
    logic              chip_sel;
    logic              adv_ld;
    logic              we_n;
    logic [LANES-1:0]  bw_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    localparam logic [DATA_W-1:0] D1  = 36'h1_2345_6789;
    localparam logic [DATA_W-1:0] D2  = 36'hA_BCDE_F012;
    localparam logic [DATA_W-1:0] D3  = 36'h5_5AA5_33CC;
    localparam logic [DATA_W-1:0] D4  = 36'hC_0FFE_E123;
    localparam logic [DATA_W-1:0] D5  = 36'h7_7777_0001;
    localparam logic [DATA_W-1:0] D6  = 36'h3_1415_9265;
    localparam logic [DATA_W-1:0] E0  = 36'h0_0000_00E0;
    localparam logic [DATA_W-1:0] E1  = 36'h1_1111_11E1;
    localparam logic [DATA_W-1:0] E2  = 36'h2_2222_22E2;
    localparam logic [DATA_W-1:0] E3  = 36'h3_3333_33E3;
    localparam logic [DATA_W-1:0] BAD = 36'hF_DEAD_BEEF;

    always #(CLK_PERIOD/2) clk = ~clk;

    lw_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lw_sram (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n    (cen_n),
        .chip_sel (chip_sel),
        .adv_ld   (adv_ld),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] b);
        logic [DATA_W-1:0] m = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!b[l]) m[l*LANE_W +: LANE_W] = '1;
        end
        return m;
    endfunction

    // Drive one cycle's inputs at the falling edge
    task automatic op(input logic c, input logic s, input logic a, input logic w,
                      input logic [LANES-1:0] b, input logic [ADDR_W-1:0] ad,
                      input logic [DATA_W-1:0] d);
        @(negedge clk);
        cen_n = c; chip_sel = s; adv_ld = a; we_n = w; bw_n = b; addr = ad; wdata = d;
    endtask

    task automatic idle(input logic [DATA_W-1:0] d);
        op(1'b0, 1'b0, 1'b0, 1'b1, '1, '0, d);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] ad);
        op(1'b0, 1'b1, 1'b0, 1'b1, '1, ad, '0);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] ad, input logic [LANES-1:0] b,
                      input logic [DATA_W-1:0] d);
        op(1'b0, 1'b1, 1'b0, 1'b0, b, ad, d);
    endtask

    task automatic chk(input string tag, input logic v, input logic [DATA_W-1:0] d);
        checks++;
        if (rvalid !== v || rdata !== d) begin
            fails++;
            $display("FAIL %s: rvalid=%b rdata=%h, expected rvalid=%b rdata=%h",
                     tag, rvalid, rdata, v, d);
        end
    endtask

    // Full write then read back, then deselect drops rvalid
    task automatic t_write_read();
        wr(6'd5, 4'b0000, '0);
        idle('0);
        idle(D1);
        rd(6'd5);
        idle('0); idle('0); idle('0);
        chk("R2 R3 read returns written word", 1'b1, D1);
        idle('0);
        chk("R7 deselect drops rvalid, data hold", 1'b0, D1);
    endtask

    // Byte-masked write over the previous word
    task automatic t_masked();
        logic [DATA_W-1:0] m   = lane_mask(4'b1010);
        logic [DATA_W-1:0] exp = (D1 & ~m) | (D2 & m);
        wr(6'd5, 4'b1010, '0);
        idle('0);
        idle(D2);
        rd(6'd5);
        idle('0); idle('0); idle('0);
        chk("R3 byte lanes 0 and 2 written", 1'b1, exp);
    endtask

    // Reads and writes on consecutive edges
    task automatic t_no_gap();
        logic [DATA_W-1:0] m   = lane_mask(4'b1010);
        logic [DATA_W-1:0] old = (D1 & ~m) | (D2 & m);
        wr(6'd7, 4'b0000, old);
        rd(6'd7);
        wr(6'd8, 4'b0000, D3);
        rd(6'd8);
        op(1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd7, D4);
        chk("R4 read right after write", 1'b1, D3);
        idle('0);
        chk("R7 write at output stage drops rvalid", 1'b0, D3);
        idle('0);
        chk("R4 second back-to-back read", 1'b1, D4);
        idle('0);
        chk("R4 repeated read of first word", 1'b1, D3);
    endtask

    // Four-beat bursts starting at low bits 2, wrapping to 0
    task automatic t_burst();
        wr(6'd14, 4'b0000, '0);
        op(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, '0);
        op(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, E0);
        op(1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 6'd0, E1);
        idle(E2);
        idle(E3);
        rd(6'd15);
        op(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, '0);
        op(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, '0);
        op(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, '0);
        chk("R5 burst beat 15", 1'b1, E1);
        idle('0);
        chk("R5 burst wrap to 12", 1'b1, E2);
        idle('0);
        chk("R5 burst beat 13", 1'b1, E3);
        idle('0);
        chk("R5 burst beat 14", 1'b1, E0);
        rd(6'd13);
        idle('0); idle('0); idle('0);
        chk("R5 read burst stored nothing", 1'b1, E3);
    endtask

    // Advance cycles after a deselect do nothing
    task automatic t_idle_advance();
        idle('0);
        op(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'd13, '0);
        op(1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 6'd13, BAD);
        idle(BAD);
        chk("R6 deselect at output", 1'b0, E3);
        idle(BAD);
        chk("R6 advance after deselect no read", 1'b0, E3);
        idle('0);
        chk("R6 second advance no read", 1'b0, E3);
        rd(6'd14);
        idle('0); idle('0); idle('0);
        chk("R6 advance after deselect stored nothing", 1'b1, E0);
    endtask

    // Byte enables and write data ignored on reads
    task automatic t_read_ignores_bw();
        wr(6'd20, 4'b0000, '0);
        idle('0);
        idle(D5);
        op(1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 6'd20, '0);
        idle('0);
        idle(BAD);
        idle('0);
        chk("R8 read with bw_n low", 1'b1, D5);
        rd(6'd20);
        idle('0); idle('0); idle('0);
        chk("R8 word unchanged after read", 1'b1, D5);
    endtask

    // Clock-enable stalls in the read and write pipelines
    task automatic t_stall();
        logic [DATA_W-1:0] m   = lane_mask(4'b1010);
        logic [DATA_W-1:0] w5  = (D1 & ~m) | (D2 & m);
        rd(6'd5);
        idle('0);
        idle('0);
        op(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 6'd5, BAD);
        chk("R9 read reaches output", 1'b1, w5);
        op(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 6'd5, BAD);
        chk("R9 stalled edge holds outputs", 1'b1, w5);
        idle('0);
        chk("R9 second stalled edge holds outputs", 1'b1, w5);
        rd(6'd5);
        idle('0); idle('0); idle('0);
        chk("R9 stalled write command ignored", 1'b1, w5);
        wr(6'd31, 4'b0000, '0);
        op(1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd0, BAD);
        idle(BAD);
        op(1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd0, BAD);
        idle(D6);
        rd(6'd31);
        idle('0); idle('0); idle('0);
        chk("R9 write data taken after stalls", 1'b1, D6);
    endtask

    initial begin
        rst_n = 1'b0; cen_n = 1'b0; chip_sel = 1'b0; adv_ld = 1'b0;
        we_n = 1'b1; bw_n = '1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 outputs during reset", 1'b0, '0);
        rst_n = 1'b1;
        idle('0); idle('0);
        chk("R1 outputs after reset", 1'b0, '0);
        t_write_read();
        t_masked();
        t_no_gap();
        t_burst();
        t_idle_advance();
        t_read_ignores_bw();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion within %0d cycles",
                     WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule